// File: doc/BRIEF.md
# Coherence Ring Stop

One stop on a one-way ring that carries cache-coherence requests. Messages come in from the upstream stop over a valid/ready stream. Each message has a hop counter in its top bits. A message whose counter is still above zero is passed downstream with the counter lowered by one. A message whose counter is zero is retired and is never sent on.

The local cache controller can put read, invalidate or read-invalidate requests onto the ring through a send port. A locally started message leaves with a hop count of three and its reply flag clear. Ring traffic always takes precedence over local injection. A stall flag tells the controller in which cycles a send would not be taken. A send offered during a stall is not stored: the controller keeps presenting it until the stall clears.

The outgoing side is a single registered stage with a valid/ready handshake. Its contents stay frozen while the downstream stop is not ready.

Top module: `coh_ring_stop`

## Requirements
- R1: After the active-low reset, out_valid_o is 0. With no traffic and out_ready_i high, ring_ready_o is 1 and stall_o is 0.
- R2: Message layout (160 bits):
  - [159:156] hop count
  - [155] read
  - [154] invalidate
  - [153] reply
  - [152:140] tag
  - [139:128] index
  - [127:0] data

  A ring message that is accepted with a nonzero hop count appears on out_data_o one cycle later. Its hop count is lowered by one and bits [155:0] are unchanged.
- R3: A ring message that is accepted with hop count 0 is dropped. If the output register was empty or draining, out_valid_o is 0 in the next cycle.
- R4: A local send that is taken produces, one cycle later, a message with:
  - hop count 3 and reply 0;
  - send_tag_i in [152:140], send_index_i in [139:128] and send_data_i in [127:0].
- R5: Request type encoding: bit 155 equals send_read_i and bit 154 equals send_inval_i. A read sets only 155, an invalidate only 154, and a read-invalidate sets both.
- R6: When ring_valid_i and send_i are both high, the ring message is the one that reaches the output.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o holds its value.
- R8: ring_ready_o is 0 exactly when the output register is full and out_ready_i is 0.
- R9: stall_o is 1 whenever ring_valid_i is 1, or the output is full and not being drained. Otherwise it is 0.
- R10: A send offered while stall_o is 1 is not taken. This includes a stall caused by a hop-count-0 message that is being dropped, in which case the output stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_valid_i | input | 1 | Upstream message valid |
| ring_data_i | input | 160 | Upstream message |
| ring_ready_o | output | 1 | Upstream message may be taken |
| send_i | input | 1 | Local send request |
| send_read_i | input | 1 | Request asks for a read |
| send_inval_i | input | 1 | Request asks for an invalidate |
| send_tag_i | input | 13 | Request tag |
| send_index_i | input | 12 | Request index |
| send_data_i | input | 128 | Request payload |
| stall_o | output | 1 | Local send would not be taken this cycle |
| out_valid_o | output | 1 | Downstream message valid |
| out_data_o | output | 160 | Downstream message |
| out_ready_i | input | 1 | Downstream stop takes the message |

## Verification
The assertions assume that the upstream stop keeps a message steady until ring_ready_o takes it, and that the local controller only treats a send as placed in a cycle where stall_o is low. The stimulus respects both:
- Ring and send inputs change only just after a falling edge.
- A stalled message is held on the inputs until the release cycle.
- Sends are presented either with a clear stall or deliberately against a stall, to show that they are refused.

Hop counts are swept over all sixteen values, and the request flags over all four combinations.

// File: rtl/coh_ring_pkg.sv
package coh_ring_pkg;
  localparam int unsigned DEF_TAG_W  = 13;
  localparam int unsigned DEF_IDX_W  = 12;
  localparam int unsigned DEF_DATA_W = 128;
  localparam int unsigned DEF_MSG_W  = 160;

  // source feeding the output register in a cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RING  = 2'd1,
    SRC_LOCAL = 2'd2
  } out_src_e;
endpackage

// File: rtl/coh_ring_hop.sv
module coh_ring_hop #(
  parameter int unsigned MSG_W   = 160,
  parameter int unsigned FIELD_W = 156
) (
  input  logic [MSG_W-1:0] msg_i,
  output logic             alive_o,
  output logic [MSG_W-1:0] fwd_o
);
  localparam int unsigned HOP_W = MSG_W - FIELD_W;

  logic [HOP_W-1:0] hop;

  assign hop     = msg_i[MSG_W-1:FIELD_W];
  assign alive_o = |hop;
  assign fwd_o   = {hop - HOP_W'(1), msg_i[FIELD_W-1:0]};
endmodule

// File: rtl/coh_ring_inject.sv
module coh_ring_inject #(
  parameter int unsigned MSG_W     = 160,
  parameter int unsigned TAG_W     = 13,
  parameter int unsigned IDX_W     = 12,
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned HOP_START = 3
) (
  input  logic              rd_i,
  input  logic              inv_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [MSG_W-1:0]  msg_o
);
  localparam int unsigned FIELD_W = 3 + TAG_W + IDX_W + DATA_W;
  localparam int unsigned HOP_W   = MSG_W - FIELD_W;

  assign msg_o = {HOP_W'(HOP_START), rd_i, inv_i, 1'b0, tag_i, idx_i, data_i};
endmodule

// File: rtl/coh_ring_out_reg.sv
module coh_ring_out_reg
  import coh_ring_pkg::*;
#(
  parameter int unsigned MSG_W = 160
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ring_valid_i,
  input  logic             ring_alive_i,
  input  logic [MSG_W-1:0] ring_msg_i,
  input  logic             send_i,
  input  logic [MSG_W-1:0] local_msg_i,
  output logic             ring_ready_o,
  output logic             stall_o,
  output logic             out_valid_o,
  output logic [MSG_W-1:0] out_data_o,
  input  logic             out_ready_i
);
  logic             valid_q;
  logic [MSG_W-1:0] data_q;
  logic             load_ok;
  out_src_e         src;

  assign load_ok      = !valid_q || out_ready_i;
  assign ring_ready_o = load_ok;
  assign stall_o      = ring_valid_i || !load_ok;

  always_comb begin
    src = SRC_NONE;
    if (load_ok) begin
      if (ring_valid_i) begin
        if (ring_alive_i) src = SRC_RING;
      end else if (send_i) begin
        src = SRC_LOCAL;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_ok) begin
      valid_q <= (src != SRC_NONE);
      if (src == SRC_RING)  data_q <= ring_msg_i;
      if (src == SRC_LOCAL) data_q <= local_msg_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  p_reset_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o);
  p_hold_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  p_hold_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(out_data_o));
  p_backpress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !ring_ready_o);
  p_stall_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> stall_o);
endmodule

// File: rtl/coh_ring_stop.sv
module coh_ring_stop
  import coh_ring_pkg::*;
#(
  parameter int unsigned TAG_W     = DEF_TAG_W,
  parameter int unsigned IDX_W     = DEF_IDX_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned MSG_W     = DEF_MSG_W,
  parameter int unsigned HOP_START = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_valid_i,
  input  logic [MSG_W-1:0]  ring_data_i,
  output logic              ring_ready_o,
  input  logic              send_i,
  input  logic              send_read_i,
  input  logic              send_inval_i,
  input  logic [TAG_W-1:0]  send_tag_i,
  input  logic [IDX_W-1:0]  send_index_i,
  input  logic [DATA_W-1:0] send_data_i,
  output logic              stall_o,
  output logic              out_valid_o,
  output logic [MSG_W-1:0]  out_data_o,
  input  logic              out_ready_i
);
  localparam int unsigned FIELD_W = 3 + TAG_W + IDX_W + DATA_W;
  localparam int unsigned HOP_W   = MSG_W - FIELD_W;
  localparam int unsigned RD_BIT  = FIELD_W - 1;
  localparam int unsigned INV_BIT = FIELD_W - 2;
  localparam int unsigned RPL_BIT = FIELD_W - 3;

  logic             ring_alive;
  logic [MSG_W-1:0] ring_fwd;
  logic [MSG_W-1:0] local_msg;

  coh_ring_hop #(.MSG_W(MSG_W), .FIELD_W(FIELD_W)) u_hop (
    .msg_i   (ring_data_i),
    .alive_o (ring_alive),
    .fwd_o   (ring_fwd)
  );

  coh_ring_inject #(
    .MSG_W(MSG_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .HOP_START(HOP_START)
  ) u_inject (
    .rd_i   (send_read_i),
    .inv_i  (send_inval_i),
    .tag_i  (send_tag_i),
    .idx_i  (send_index_i),
    .data_i (send_data_i),
    .msg_o  (local_msg)
  );

  coh_ring_out_reg #(.MSG_W(MSG_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ring_valid_i (ring_valid_i),
    .ring_alive_i (ring_alive),
    .ring_msg_i   (ring_fwd),
    .send_i       (send_i),
    .local_msg_i  (local_msg),
    .ring_ready_o (ring_ready_o),
    .stall_o      (stall_o),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i)
  );

  p_fwd_hop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_valid_i && ring_ready_o && ring_data_i[MSG_W-1:FIELD_W] != '0) |=>
      (out_valid_o && out_data_o[MSG_W-1:FIELD_W] ==
        HOP_W'($past(ring_data_i[MSG_W-1:FIELD_W]) - HOP_W'(1))));
  p_fwd_body_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_valid_i && ring_ready_o && ring_data_i[MSG_W-1:FIELD_W] != '0) |=>
      (out_data_o[FIELD_W-1:0] == $past(ring_data_i[FIELD_W-1:0])));
  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_valid_i && ring_ready_o && ring_data_i[MSG_W-1:FIELD_W] == '0) |=> !out_valid_o);
  p_local_hdr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !stall_o) |=>
      (out_valid_o && out_data_o[MSG_W-1:FIELD_W] == HOP_W'(HOP_START) && !out_data_o[RPL_BIT]));
  p_local_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !stall_o) |=> (out_data_o[RPL_BIT-1 -: TAG_W] == $past(send_tag_i)));
  p_type_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !stall_o) |=>
      (out_data_o[RD_BIT] == $past(send_read_i) && out_data_o[INV_BIT] == $past(send_inval_i)));
  p_ring_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_valid_i |-> stall_o);
endmodule

// File: tb/coh_ring_stop_test.sv
module coh_ring_stop_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ring_valid = 1'b0;
  logic [159:0]  ring_data = '0;
  logic          ring_ready;
  logic          send = 1'b0;
  logic          send_rd = 1'b0;
  logic          send_inv = 1'b0;
  logic [12:0]   send_tag = '0;
  logic [11:0]   send_idx = '0;
  logic [127:0]  send_dat = '0;
  logic          stall;
  logic          out_valid;
  logic [159:0]  out_data;
  logic          out_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  coh_ring_stop uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ring_valid_i(ring_valid), .ring_data_i(ring_data), .ring_ready_o(ring_ready),
    .send_i(send), .send_read_i(send_rd), .send_inval_i(send_inv),
    .send_tag_i(send_tag), .send_index_i(send_idx), .send_data_i(send_dat),
    .stall_o(stall), .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] mk(input int k, input int hop);
    logic [155:0] body;
    body = {28'(k * 7 + 3), 32'(k * 32'h9E3779B9), 32'(k ^ 32'h5A5A1234),
            32'(~k), 32'(k * k + 1)};
    return {4'(hop), body};
  endfunction

  function automatic logic [159:0] fwd(input logic [159:0] m);
    return m - (160'd1 << 156);
  endfunction

  function automatic logic [159:0] loc(input logic rd, input logic inv,
      input logic [12:0] t, input logic [11:0] x, input logic [127:0] d);
    return {4'd3, rd, inv, 1'b0, t, x, d};
  endfunction

  task automatic idle();
    ring_valid = 1'b0;
    send = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [159:0] held;
    logic [159:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 160'(out_valid), 160'd0);
    chk("R1 ring_ready", 160'(ring_ready), 160'd1);
    chk("R1 stall", 160'(stall), 160'd0);

    // R2 forward over every nonzero hop count
    for (int h = 1; h < 16; h++) begin
      m = mk(h + 100, h);
      ring_data = m; ring_valid = 1'b1;
      #1 chk("R2 ring_ready", 160'(ring_ready), 160'd1);
      @(negedge clk);
      chk("R2 valid", 160'(out_valid), 160'd1);
      chk("R2 data", out_data, fwd(m));
    end
    // R3 hop 0 dropped
    for (int k = 0; k < 4; k++) begin
      ring_data = mk(k + 7, 0); ring_valid = 1'b1;
      @(negedge clk);
      chk("R3 dropped", 160'(out_valid), 160'd0);
    end
    idle();
    @(negedge clk);

    // R4 R5 local sends, all flag combos, back-to-back
    for (int ty = 0; ty < 4; ty++) begin
      for (int k = 0; k < 3; k++) begin
        send = 1'b1; send_rd = ty[0]; send_inv = ty[1];
        send_tag = 13'(ty * 1777 + k * 611 + 1);
        send_idx = 12'(k * 1301 + ty * 97);
        send_dat = {32'(k), 32'(ty * 32'h1234567), 32'hDEADBEEF ^ 32'(k), 32'(ty + k)};
        #1 chk("R9 stall clear", 160'(stall), 160'd0);
        @(negedge clk);
        chk("R4 valid", 160'(out_valid), 160'd1);
        chk("R4 R5 data", out_data, loc(send_rd, send_inv, send_tag, send_idx, send_dat));
      end
    end
    idle();
    @(negedge clk);

    // R6 ring wins over simultaneous send
    m = mk(55, 2);
    ring_data = m; ring_valid = 1'b1;
    send = 1'b1; send_rd = 1'b1; send_inv = 1'b0; send_tag = 13'h123; send_idx = 12'h456;
    send_dat = 128'h1;
    #1 chk("R6 stall", 160'(stall), 160'd1);
    @(negedge clk);
    chk("R6 ring first", out_data, fwd(m));
    ring_valid = 1'b0;
    @(negedge clk);
    chk("R6 local after", out_data, loc(1'b1, 1'b0, 13'h123, 12'h456, 128'h1));
    idle();
    @(negedge clk);

    // R7 R8 R9 backpressure
    out_ready = 1'b0;
    send = 1'b1; send_rd = 1'b0; send_inv = 1'b1; send_tag = 13'h1ABC; send_idx = 12'hFED;
    send_dat = 128'hCAFE;
    @(negedge clk);
    held = loc(1'b0, 1'b1, 13'h1ABC, 12'hFED, 128'hCAFE);
    chk("R7 loaded", out_data, held);
    m = mk(77, 9);
    ring_data = m; ring_valid = 1'b1;
    send_tag = 13'h0F0;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk("R8 ring_ready low", 160'(ring_ready), 160'd0);
      chk("R9 stall full", 160'(stall), 160'd1);
      @(negedge clk);
      chk("R7 valid held", 160'(out_valid), 160'd1);
      chk("R7 data held", out_data, held);
    end
    ring_valid = 1'b0;
    #1 chk("R9 stall full no ring", 160'(stall), 160'd1);
    ring_valid = 1'b1;
    out_ready = 1'b1;
    #1 chk("R8 ring_ready drain", 160'(ring_ready), 160'd1);
    @(negedge clk);
    chk("R8 ring after drain", out_data, fwd(m));
    idle();
    @(negedge clk);
    chk("R8 emptied", 160'(out_valid), 160'd0);

    // R10 send refused while a hop-0 message is dropped
    ring_data = mk(3, 0); ring_valid = 1'b1;
    send = 1'b1; send_rd = 1'b1; send_inv = 1'b1; send_tag = 13'h77; send_idx = 12'h11;
    send_dat = 128'h99;
    #1 chk("R10 stall", 160'(stall), 160'd1);
    @(negedge clk);
    chk("R10 nothing out", 160'(out_valid), 160'd0);
    ring_valid = 1'b0;
    @(negedge clk);
    chk("R10 retry taken", out_data, loc(1'b1, 1'b1, 13'h77, 12'h11, 128'h99));
    idle();
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule